// File: doc/BRIEF.md
# Test-and-Set Lock Register

This block is a single-word memory-mapped lock for software running on one or more processors. Each requester reaches it through its own request/response slave port. A port carries valid, ready, a write flag, a word offset, write data and byte enables, and it has a response strobe. The response read data is shared by all ports. A read at offset zero returns the word held before the access. In the same step the read leaves the register holding one, so the read acts as a hardware test-and-set. A write at offset zero stores the supplied data. Software takes the lock by reading until a zero comes back and releases it by writing zero. Decoding of the block's base address happens upstream, so the block only ever sees its local offset.

Accesses are strictly serialised. The control state machine has two states, `ST_IDLE` and `ST_RESP`. It has three named transitions:
- `T_WAIT`: stay in `ST_IDLE` while no request is pending.
- `T_ACCEPT`: go from `ST_IDLE` to `ST_RESP` when the arbiter grants a pending request. The register is updated on this edge.
- `T_DONE`: go from `ST_RESP` back to `ST_IDLE` after the one-cycle response strobe.

Top module: `tas_lock`

## Requirements
- R1: After reset the stored word is zero, no port sees ready or a response strobe, and the first read at offset 0 returns 0.
- R2: A read at offset 0 returns the word held before the access and leaves the register holding 1. The byte enables of a read are ignored.
- R3: A write at offset 0 with all byte enables set (4'b1111) replaces the whole stored word.
- R4: A write at offset 0 with partial byte enables updates only the enabled bytes. Enable bit i controls data bits 8i+7:8i. Such a write never sets the register to 1.
- R5: A read at any offset other than 0 returns 0 and leaves the stored word unchanged.
- R6: A write at any offset other than 0 is ignored.
- R7: Each accepted request gets exactly one response strobe, one cycle wide. The strobe appears on the accepting port only, in the cycle after acceptance. Write responses carry read data 0.
- R8: When several ports request at once, the lowest-numbered port is accepted first. At most one port sees ready in any cycle, and no port is accepted while a response is outstanding.
- R9: A lock released by a write of 0 is granted to exactly one following reader: that read returns 0 and every later read returns 1 until the next release.
- R10: Ready is only given to a port whose valid is high. A requester holds its request until it sees ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_PORTS | Request valid, one bit per port |
| req_ready | output | NUM_PORTS | Request accepted this cycle, one bit per port |
| req_write | input | NUM_PORTS | 1 = write, 0 = read, per port |
| req_addr | input | NUM_PORTS*ADDR_W | Word offset per port, packed, port 0 in the low bits |
| req_wdata | input | NUM_PORTS*DATA_W | Write data per port, packed |
| req_be | input | NUM_PORTS*DATA_W/8 | Write byte enables per port, packed |
| rsp_valid | output | NUM_PORTS | One-cycle response strobe per port |
| rsp_rdata | output | DATA_W | Response data, valid while any response strobe is high |

## Verification
A request is accepted on the rising edge where its port's ready is high. The response strobe and data for it are due exactly one cycle later. Ready for the next request can appear one cycle after that. The bench drives on falling edges and waits for ready at a falling edge. It lets the accepting rising edge pass, and the monitor then samples the strobe and data at the following falling edge. The monitor also checks that no strobe appears in any other cycle. Simultaneous requests are queued in the scoreboard in the order fixed priority serves them, so any ordering error shows up as a port or data mismatch.

// File: rtl/tas_pkg.sv
package tas_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } tas_state_t;
endpackage

// File: rtl/tas_arbiter.sv
module tas_arbiter #(
    parameter int NUM_PORTS = 3
) (
    input  logic [NUM_PORTS-1:0] req,
    output logic [NUM_PORTS-1:0] grant,
    output logic                 any_req
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        grant = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (req[i] && !taken) begin
                grant[i] = 1'b1;
                taken    = 1'b1;
            end
        end
    end

    assign any_req = |req;
endmodule

// File: rtl/tas_fsm.sv
module tas_fsm
    import tas_pkg::*;
#(
    parameter int NUM_PORTS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 any_req,
    input  logic [NUM_PORTS-1:0] grant,
    output logic [NUM_PORTS-1:0] ready,
    output logic [NUM_PORTS-1:0] rsp,
    output logic                 accept
);
    tas_state_t          state_q, state_d;
    logic [NUM_PORTS-1:0] owner_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (any_req) state_d = ST_RESP;  // T_ACCEPT, else T_WAIT
            ST_RESP: state_d = ST_IDLE;               // T_DONE
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && any_req) owner_q <= grant;
        end
    end

    always_comb begin
        ready  = '0;
        rsp    = '0;
        accept = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready  = grant;
                accept = any_req;
            end
            ST_RESP: rsp = owner_q;
            default: ;
        endcase
    end

    // R8: at most one port accepted per cycle
    a_r8_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ready));
    // R7: the accepting port gets the strobe in the next cycle
    a_r7_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (rsp == $past(ready)));
    // R7: strobe lasts one cycle
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp) |=> (rsp == '0));
    // R8: nothing accepted while a response is outstanding
    a_r8_serial: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp) |-> (ready == '0));
endmodule

// File: rtl/tas_store.sv
module tas_store #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_en,
    input  logic                acc_write,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [DATA_W-1:0]   acc_wdata,
    input  logic [DATA_W/8-1:0] acc_be,
    output logic [DATA_W-1:0]   rd_data
);
    localparam int BE_W = DATA_W / 8;

    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] merged;
    logic              hit;

    assign hit = (acc_addr == '0);

    always_comb begin
        merged = word_q;
        for (int b = 0; b < BE_W; b++) begin
            if (acc_be[b]) merged[8*b +: 8] = acc_wdata[8*b +: 8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            rd_data <= '0;
        end else if (acc_en) begin
            if (hit && acc_write) begin
                word_q  <= merged;
                rd_data <= '0;
            end else if (hit) begin
                rd_data <= word_q;
                word_q  <= {{(DATA_W-1){1'b0}}, 1'b1};
            end else begin
                rd_data <= '0;
            end
        end
    end

    // R2: a read at offset 0 leaves the word at one
    a_r2_set_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_write && hit) |=> (word_q == {{(DATA_W-1){1'b0}}, 1'b1}));
    // R5, R6: accesses elsewhere leave the word untouched
    a_r5_miss_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !hit) |=> $stable(word_q));
    // R5: misses return zero
    a_r5_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !hit) |=> (rd_data == '0));
endmodule

// File: rtl/tas_lock.sv
module tas_lock #(
    parameter int NUM_PORTS = 3,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_PORTS-1:0]            req_valid,
    output logic [NUM_PORTS-1:0]            req_ready,
    input  logic [NUM_PORTS-1:0]            req_write,
    input  logic [NUM_PORTS*ADDR_W-1:0]     req_addr,
    input  logic [NUM_PORTS*DATA_W-1:0]     req_wdata,
    input  logic [NUM_PORTS*DATA_W/8-1:0]   req_be,
    output logic [NUM_PORTS-1:0]            rsp_valid,
    output logic [DATA_W-1:0]               rsp_rdata
);
    localparam int BE_W = DATA_W / 8;

    logic [NUM_PORTS-1:0] grant;
    logic                 any_req;
    logic                 accept;
    logic                 sel_write;
    logic [ADDR_W-1:0]    sel_addr;
    logic [DATA_W-1:0]    sel_wdata;
    logic [BE_W-1:0]      sel_be;

    tas_arbiter #(.NUM_PORTS(NUM_PORTS)) u_arb (
        .req     (req_valid),
        .grant   (grant),
        .any_req (any_req)
    );

    tas_fsm #(.NUM_PORTS(NUM_PORTS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_req (any_req),
        .grant   (grant),
        .ready   (req_ready),
        .rsp     (rsp_valid),
        .accept  (accept)
    );

    always_comb begin
        sel_write = 1'b0;
        sel_addr  = '0;
        sel_wdata = '0;
        sel_be    = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (grant[p]) begin
                sel_write = sel_write | req_write[p];
                sel_addr  = sel_addr  | req_addr[p*ADDR_W +: ADDR_W];
                sel_wdata = sel_wdata | req_wdata[p*DATA_W +: DATA_W];
                sel_be    = sel_be    | req_be[p*BE_W +: BE_W];
            end
        end
    end

    tas_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (accept),
        .acc_write (sel_write),
        .acc_addr  (sel_addr),
        .acc_wdata (sel_wdata),
        .acc_be    (sel_be),
        .rd_data   (rsp_rdata)
    );

    // R10: ready only toward a requesting port
    a_r10_ready_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_ready & ~req_valid) == '0));
    // R8: a pending request is never left without a grant while idle and no response pending
    a_r8_progress: assert property (@(posedge clk) disable iff (!rst_n)
        ((|req_valid) && (rsp_valid == '0)) |-> (|req_ready));
endmodule

// File: tb/tas_lock_bench.sv
module tas_lock_bench;
    localparam int NP = 3;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam int BW = DW / 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     req_valid = '0;
    logic [NP-1:0]     req_ready;
    logic [NP-1:0]     req_write = '0;
    logic [NP*AW-1:0]  req_addr = '0;
    logic [NP*DW-1:0]  req_wdata = '0;
    logic [NP*BW-1:0]  req_be = '0;
    logic [NP-1:0]     rsp_valid;
    logic [DW-1:0]     rsp_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int          port;
        logic [DW-1:0] data;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    tas_lock #(.NUM_PORTS(NP), .DATA_W(DW), .ADDR_W(AW)) u_tas_lock (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_rsp(input int p, input logic [DW-1:0] d, input string tag);
        exp_t e;
        e.port = p; e.data = d; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drive(input int p, input bit w, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [BW-1:0] be);
        @(negedge clk);
        req_write[p]          = w;
        req_addr[p*AW +: AW]  = a;
        req_wdata[p*DW +: DW] = d;
        req_be[p*BW +: BW]    = be;
        req_valid[p]          = 1'b1;
        forever begin
            #1;
            if (req_ready[p]) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        req_valid[p] = 1'b0;
    endtask

    // monitor: pop and compare on every strobe, sampled at falling edges
    always @(negedge clk) begin
        if (rst_n && rsp_valid != '0) begin
            if (sb.size() == 0) begin
                check(1'b0, "R7 unexpected response", DW'(rsp_valid), '0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_valid == NP'(1 << e.port), {e.tag, " port"},
                      DW'(rsp_valid), DW'(1 << e.port));
                check(rsp_rdata == e.data, {e.tag, " data"}, rsp_rdata, e.data);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog expired", '0, '0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == '0 && rsp_valid == '0, "R1 idle during reset",
              DW'({req_ready, rsp_valid}), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == '0, "R1 no strobe after reset", DW'(rsp_valid), '0);

        expect_rsp(0, 32'd0, "R1 first read");            drive(0, 0, 0, 0, 4'hF);
        expect_rsp(0, 32'd1, "R2 read after read");       drive(0, 0, 0, 0, 4'h0);
        expect_rsp(1, 32'd0, "R3 R7 full write resp");    drive(1, 1, 0, 32'hAABBCCDD, 4'hF);
        expect_rsp(1, 32'd0, "R4 partial write resp");    drive(1, 1, 0, 32'h11223344, 4'b0101);
        expect_rsp(2, 32'd0, "R5 miss read");             drive(2, 0, 4'd3, 0, 4'hF);
        expect_rsp(0, 32'd0, "R6 miss write resp");       drive(0, 1, 4'd2, 32'hFFFFFFFF, 4'hF);
        expect_rsp(0, 32'hAA22CC44, "R4 R5 R6 merged value"); drive(0, 0, 0, 0, 4'hF);
        expect_rsp(0, 32'd1, "R2 set after read");        drive(0, 0, 0, 0, 4'hF);

        // R9 release and reacquire
        expect_rsp(1, 32'd0, "R9 release resp");          drive(1, 1, 0, 32'd0, 4'hF);
        expect_rsp(2, 32'd0, "R9 acquire");               drive(2, 0, 0, 0, 4'hF);
        expect_rsp(1, 32'd1, "R9 second reader blocked"); drive(1, 0, 0, 0, 4'hF);

        // R8 simultaneous readers after release
        expect_rsp(0, 32'd0, "R9 release resp 2");        drive(0, 1, 0, 32'd0, 4'hF);
        expect_rsp(0, 32'd0, "R8 port0 wins lock");
        expect_rsp(1, 32'd1, "R8 port1 after");
        expect_rsp(2, 32'd1, "R8 port2 last");
        fork
            drive(2, 0, 0, 0, 4'hF);
            drive(1, 0, 0, 0, 4'hF);
            drive(0, 0, 0, 0, 4'hF);
        join

        // R8 read on port1 beats write on port2; R10 write held until ready
        expect_rsp(1, 32'd1, "R8 R10 read before write");
        expect_rsp(2, 32'd0, "R8 R10 write served second");
        fork
            drive(2, 1, 0, 32'd0, 4'hF);
            drive(1, 0, 0, 0, 4'hF);
        join
        expect_rsp(0, 32'd0, "R8 R9 write applied last"); drive(0, 0, 0, 0, 4'hF);

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R7 responses missing", DW'(sb.size()), '0);
        finish_run();
    end
endmodule